// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from a set of on-chip peripheral lines and from a group of external request inputs. It offers the single most urgent request to a CPU core. Each source has a 4-bit priority held in a small configuration register file. A priority of 0 switches the source off. The external inputs work in one of two modes. In pin mode, each external line is a separate source with its own priority. In level mode, a 4-bit code gives the request priority directly.

The winning request is offered on a valid/ready pair (`irq_valid`/`irq_ready`), together with its priority and its vector number. A request is offered only while its priority is strictly above the CPU's current mask level. Back-pressure rules:
- The controller holds `irq_valid` for as long as a qualifying source stays pending. No request is consumed until `irq_ready` is seen high in the same cycle.
- Because the inputs are level-sensitive, the offered request can change while it waits. A higher-priority arrival replaces it, and a request that is withdrawn drops `irq_valid`.

On a handshake, the controller registers three values: the vector, the vector table address (base plus four times the vector), and the new mask value. The new mask value equals the accepted priority. These outputs appear on the next cycle with a one-cycle `ack_vld` strobe and keep their value until the next handshake. The CPU exception sequence and the fetch of the vector belong to the core.

Top module: `prio_vic`

## Requirements
- R1: After reset, every priority field is 0, pin mode is selected, the vector base is 0, `irq_valid` and `ack_vld` are low, and `ack_vec`, `ack_addr` and `ack_mask` are 0.
- R2: A source whose priority field is 0 never produces a request, even while its line is asserted.
- R3: Among pending enabled sources, the one with the highest priority is offered on `irq_vec`/`irq_level`. External pin i has vector 80+i, peripheral line j has vector 96+j, and level-mode level L has vector 64+L.
- R4: When pending sources tie on the highest priority, the one with the lowest candidate index wins. The order is: the level-mode source first, then external pins 0 upward, then peripherals 0 upward.
- R5: `irq_valid` is high only when the winning priority is strictly greater than `cpu_mask`.
- R6: Configuration writes (`cfg_wr` high at a clock edge) use the following register map:
  - sel 0, bit 0: external mode (0 = pin, 1 = level).
  - sel 1: vector base.
  - sel 2+k/8, bits 4*(k%8)+3 down to 4*(k%8): priority of source k. Sources 0..7 are external pins 0..7; sources 8..23 are peripherals 0..15.
  - Each write takes effect from the next cycle.
- R7: In level mode, `ext_lvl` values 15..1 are a request of that priority, and 0 means no external request. The individual `ext_irq` lines are ignored. In pin mode, `ext_lvl` is ignored.
- R8: A cycle with both `irq_valid` and `irq_ready` high makes `ack_vld` high in the next cycle for exactly one cycle. In that cycle:
  - `ack_vec` holds the accepted vector.
  - `ack_addr` equals base + 4*vector.
  - `ack_mask` equals the accepted priority.
  These values stay unchanged until the next handshake.
- R9: While `irq_ready` stays low, a pending qualifying request keeps `irq_valid` high and no `ack_vld` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| ext_irq | input | NUM_EXT | External request lines (pin mode) |
| ext_lvl | input | 4 | Encoded external level (level mode) |
| per_irq | input | NUM_PER | Peripheral request lines |
| cpu_mask | input | 4 | Current CPU mask level |
| irq_valid | output | 1 | Request offered to the core |
| irq_ready | input | 1 | Core accepts the offered request |
| irq_level | output | 4 | Priority of the offered request |
| irq_vec | output | VEC_W | Vector number of the offered request |
| ack_vld | output | 1 | One-cycle strobe after a handshake |
| ack_vec | output | VEC_W | Accepted vector number |
| ack_addr | output | ADDR_W | Vector table address of accepted request |
| ack_mask | output | 4 | New CPU mask value (accepted priority) |

## Verification
The request path is purely combinational from the registered configuration. A corrupted priority field or mode bit therefore shows up on `irq_valid`, `irq_level` and `irq_vec` in the same cycle a source is asserted. A wrong tie order or a wrong mask comparison shows the same way, at once.

A fault in the acceptance registers shows one cycle after a handshake. It appears as a missing or doubled `ack_vld`, or as an address that does not equal base plus four times the vector. A register that fails to hold shows as `ack_*` drifting between handshakes.

// File: rtl/prio_vic_pkg.sv
package prio_vic_pkg;
  localparam int PRIO_W       = 4;
  localparam int NIB_PER_WORD = 8;
  localparam int SEL_CTRL     = 0;
  localparam int SEL_BASE     = 1;
  localparam int SEL_PRIO0    = 2;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef enum logic {
    EXT_PINS  = 1'b0,
    EXT_LEVEL = 1'b1
  } ext_mode_e;
endpackage

// File: rtl/prio_vic_regs.sv
module prio_vic_regs
  import prio_vic_pkg::*;
#(
  parameter int NUM_PROG = 24,
  parameter int ADDR_W   = 32,
  parameter int SEL_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [SEL_W-1:0]           cfg_sel,
  input  logic [31:0]                cfg_wdata,
  output ext_mode_e                  mode,
  output logic [ADDR_W-1:0]          vec_base,
  output logic [NUM_PROG*PRIO_W-1:0] prio_flat
);
  localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(SEL_CTRL);
  localparam logic [SEL_W-1:0] BASE_SEL = SEL_W'(SEL_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= EXT_PINS;
      vec_base <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel == CTRL_SEL) mode <= ext_mode_e'(cfg_wdata[0]);
      if (cfg_sel == BASE_SEL) vec_base <= cfg_wdata[ADDR_W-1:0];
    end
  end

  for (genvar k = 0; k < NUM_PROG; k++) begin : g_prio
    localparam logic [SEL_W-1:0] WSEL = SEL_W'(SEL_PRIO0 + k / NIB_PER_WORD);
    localparam int LSB = PRIO_W * (k % NIB_PER_WORD);
    prio_t prio_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q <= '0;
      else if (cfg_wr && cfg_sel == WSEL) prio_q <= cfg_wdata[LSB +: PRIO_W];
    end
    assign prio_flat[k*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/prio_vic_srcmap.sv
module prio_vic_srcmap
  import prio_vic_pkg::*;
#(
  parameter int NUM_EXT      = 8,
  parameter int NUM_PER      = 16,
  parameter int VEC_W        = 8,
  parameter int LVL_VEC_BASE = 64,
  parameter int EXT_VEC_BASE = 80,
  parameter int PER_VEC_BASE = 96,
  localparam int NUM_PROG    = NUM_EXT + NUM_PER,
  localparam int NC          = 1 + NUM_PROG
) (
  input  ext_mode_e                  mode,
  input  logic [NUM_EXT-1:0]         ext_irq,
  input  prio_t                      ext_lvl,
  input  logic [NUM_PER-1:0]         per_irq,
  input  logic [NUM_PROG*PRIO_W-1:0] prio_flat,
  output logic [NC*PRIO_W-1:0]       cand_prio,
  output logic [NC*VEC_W-1:0]        cand_vec
);
  // candidate 0: encoded external level
  assign cand_prio[0 +: PRIO_W] = (mode == EXT_LEVEL) ? ext_lvl : '0;
  assign cand_vec[0 +: VEC_W]   = VEC_W'(LVL_VEC_BASE) + VEC_W'(ext_lvl);

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    localparam int C = 1 + i;
    assign cand_prio[C*PRIO_W +: PRIO_W] =
      (mode == EXT_PINS && ext_irq[i]) ? prio_flat[i*PRIO_W +: PRIO_W] : '0;
    assign cand_vec[C*VEC_W +: VEC_W] = VEC_W'(EXT_VEC_BASE + i);
  end

  for (genvar j = 0; j < NUM_PER; j++) begin : g_per
    localparam int C = 1 + NUM_EXT + j;
    localparam int P = NUM_EXT + j;
    assign cand_prio[C*PRIO_W +: PRIO_W] =
      per_irq[j] ? prio_flat[P*PRIO_W +: PRIO_W] : '0;
    assign cand_vec[C*VEC_W +: VEC_W] = VEC_W'(PER_VEC_BASE + j);
  end
endmodule

// File: rtl/prio_vic_arb.sv
module prio_vic_arb
  import prio_vic_pkg::*;
#(
  parameter int NC    = 25,
  parameter int VEC_W = 8
) (
  input  logic [NC*PRIO_W-1:0] cand_prio,
  input  logic [NC*VEC_W-1:0]  cand_vec,
  output prio_t                win_prio,
  output logic [VEC_W-1:0]     win_vec
);
  // Strict compare: on equal priority the earlier (lower index) candidate stays.
  always_comb begin
    win_prio = '0;
    win_vec  = '0;
    for (int c = 0; c < NC; c++) begin
      if (cand_prio[c*PRIO_W +: PRIO_W] > win_prio) begin
        win_prio = cand_prio[c*PRIO_W +: PRIO_W];
        win_vec  = cand_vec[c*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import prio_vic_pkg::*;
#(
  parameter int NUM_EXT      = 8,
  parameter int NUM_PER      = 16,
  parameter int VEC_W        = 8,
  parameter int ADDR_W       = 32,
  parameter int SEL_W        = 4,
  parameter int LVL_VEC_BASE = 64,
  parameter int EXT_VEC_BASE = 80,
  parameter int PER_VEC_BASE = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [3:0]         ext_lvl,
  input  logic [NUM_PER-1:0] per_irq,
  input  logic [3:0]         cpu_mask,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [3:0]         irq_level,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               ack_vld,
  output logic [VEC_W-1:0]   ack_vec,
  output logic [ADDR_W-1:0]  ack_addr,
  output logic [3:0]         ack_mask
);
  localparam int NUM_PROG = NUM_EXT + NUM_PER;
  localparam int NC       = 1 + NUM_PROG;

  ext_mode_e                  mode;
  logic                       mode_enc;
  logic [ADDR_W-1:0]          vec_base;
  logic [NUM_PROG*PRIO_W-1:0] prio_flat;
  logic [NC*PRIO_W-1:0]       cand_prio;
  logic [NC*VEC_W-1:0]        cand_vec;
  prio_t                      win_prio;
  logic [VEC_W-1:0]           win_vec;
  logic                       take;

  prio_vic_regs #(.NUM_PROG(NUM_PROG), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata,
    .mode, .vec_base, .prio_flat
  );

  prio_vic_srcmap #(
    .NUM_EXT(NUM_EXT), .NUM_PER(NUM_PER), .VEC_W(VEC_W),
    .LVL_VEC_BASE(LVL_VEC_BASE), .EXT_VEC_BASE(EXT_VEC_BASE),
    .PER_VEC_BASE(PER_VEC_BASE)
  ) u_map (
    .mode, .ext_irq, .ext_lvl, .per_irq, .prio_flat, .cand_prio, .cand_vec
  );

  prio_vic_arb #(.NC(NC), .VEC_W(VEC_W)) u_arb (
    .cand_prio, .cand_vec, .win_prio, .win_vec
  );

  assign mode_enc  = (mode == EXT_LEVEL);
  assign irq_valid = (win_prio > cpu_mask);
  assign irq_level = win_prio;
  assign irq_vec   = win_vec;
  assign take      = irq_valid && irq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld  <= 1'b0;
      ack_vec  <= '0;
      ack_addr <= '0;
      ack_mask <= '0;
    end else begin
      ack_vld <= take;
      if (take) begin
        ack_vec  <= win_vec;
        ack_addr <= vec_base + ADDR_W'({win_vec, 2'b00});
        ack_mask <= win_prio;
      end
    end
  end
endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk #(
  parameter int NUM_PER = 16,
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic [3:0]         irq_level,
  input logic [3:0]         cpu_mask,
  input logic               ack_vld,
  input logic [VEC_W-1:0]   ack_vec,
  input logic [ADDR_W-1:0]  ack_addr,
  input logic [3:0]         ack_mask,
  input logic               mode_enc,
  input logic [3:0]         ext_lvl,
  input logic [NUM_PER-1:0] per_irq
);
  // R8
  ack_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> ack_vld);

  // R9
  no_ack_without_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && irq_ready) |=> !ack_vld);

  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && irq_ready) |=> ($stable(ack_vec) && $stable(ack_mask) && $stable(ack_addr)));

  // R8
  ack_mask_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> (ack_mask == $past(irq_level)));

  // R5
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level > cpu_mask));

  // R2
  nonzero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level != 4'd0));

  // R7
  level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_enc && ext_lvl == 4'd0 && per_irq == '0) |-> !irq_valid);
endmodule

bind prio_vic prio_vic_chk #(.NUM_PER(NUM_PER), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_level(irq_level), .cpu_mask(cpu_mask), .ack_vld(ack_vld),
  .ack_vec(ack_vec), .ack_addr(ack_addr), .ack_mask(ack_mask),
  .mode_enc(mode_enc), .ext_lvl(ext_lvl), .per_irq(per_irq)
);

// File: tb/prio_vic_bench.sv
`timescale 1ns/1ps
module prio_vic_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  ext_irq = '0;
  logic [3:0]  ext_lvl = '0;
  logic [15:0] per_irq = '0;
  logic [3:0]  cpu_mask = '0;
  logic        irq_ready = 1'b0;
  logic        irq_valid, ack_vld;
  logic [3:0]  irq_level, ack_mask;
  logic [7:0]  irq_vec, ack_vec;
  logic [31:0] ack_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic cur_mode = 1'b0;

  always #4 clk = ~clk;

  prio_vic u_prio_vic (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata, .ext_irq, .ext_lvl, .per_irq,
    .cpu_mask, .irq_valid, .irq_ready, .irq_level, .irq_vec,
    .ack_vld, .ack_vec, .ack_addr, .ack_mask
  );

  // Priorities: pins 0..7 = 3,7,7,0,1,2,12,5 ; periph 0..4 = 4,9,9,0,15 ; periph 5..15 = 2
  localparam logic [31:0] W_PINS = 32'h5C21_0773;
  localparam logic [31:0] W_PER0 = 32'h222F_0994;
  localparam logic [31:0] W_PER1 = 32'h2222_2222;
  localparam logic [31:0] BASE0  = 32'h0000_1000;

  // {mode, ext_irq, ext_lvl, per_irq, cpu_mask, exp_valid, exp_vec, exp_level}
  localparam int NV = 18;
  localparam logic [45:0] TBL [NV] = '{
    {1'b0, 8'h00, 4'd0,  16'h0000, 4'd0,  1'b0, 8'd0,   4'd0},  // idle
    {1'b0, 8'h01, 4'd0,  16'h0000, 4'd0,  1'b1, 8'd80,  4'd3},  // R3 pin0
    {1'b0, 8'h06, 4'd0,  16'h0000, 4'd0,  1'b1, 8'd81,  4'd7},  // R4 tie pins
    {1'b0, 8'h08, 4'd0,  16'h0008, 4'd0,  1'b0, 8'd0,   4'd0},  // R2 prio 0
    {1'b0, 8'h01, 4'd0,  16'h0001, 4'd0,  1'b1, 8'd96,  4'd4},  // R3
    {1'b0, 8'h40, 4'd0,  16'h0010, 4'd0,  1'b1, 8'd100, 4'd15}, // R3
    {1'b0, 8'h40, 4'd0,  16'h0010, 4'd15, 1'b0, 8'd0,   4'd0},  // R5 mask 15
    {1'b0, 8'h40, 4'd0,  16'h0000, 4'd12, 1'b0, 8'd0,   4'd0},  // R5 equal
    {1'b0, 8'h40, 4'd0,  16'h0000, 4'd11, 1'b1, 8'd86,  4'd12}, // R5 one below
    {1'b0, 8'h00, 4'd0,  16'h0006, 4'd0,  1'b1, 8'd97,  4'd9},  // R4 tie periph
    {1'b0, 8'h00, 4'd15, 16'h0000, 4'd0,  1'b0, 8'd0,   4'd0},  // R7 lvl ignored
    {1'b1, 8'h00, 4'd5,  16'h0000, 4'd0,  1'b1, 8'd69,  4'd5},  // R7
    {1'b1, 8'h40, 4'd0,  16'h0000, 4'd0,  1'b0, 8'd0,   4'd0},  // R7 pins ignored
    {1'b1, 8'h00, 4'd9,  16'h0002, 4'd0,  1'b1, 8'd73,  4'd9},  // R4 level first
    {1'b1, 8'h00, 4'd3,  16'h0001, 4'd0,  1'b1, 8'd96,  4'd4},  // R3
    {1'b1, 8'h00, 4'd15, 16'h0000, 4'd14, 1'b1, 8'd79,  4'd15}, // R7
    {1'b1, 8'h00, 4'd1,  16'h0020, 4'd1,  1'b1, 8'd101, 4'd2},  // R5
    {1'b0, 8'h80, 4'd0,  16'hFFE0, 4'd0,  1'b1, 8'd87,  4'd5}   // R3 many
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  // handshake, then check the registered acceptance outputs
  task automatic handshake(input logic [7:0] ev, input logic [3:0] el, input logic [31:0] base, input string req);
    @(negedge clk);
    irq_ready = 1'b1;
    @(posedge clk); #1;
    irq_ready = 1'b0;
    @(negedge clk);
    check(ack_vld === 1'b1, req, 64'(ack_vld), 64'd1);
    check(ack_vec === ev, req, 64'(ack_vec), 64'(ev));
    check(ack_mask === el, req, 64'(ack_mask), 64'(el));
    check(ack_addr === base + {22'd0, ev, 2'b00}, req, 64'(ack_addr), 64'(base + {22'd0, ev, 2'b00}));
    @(negedge clk);
    check(ack_vld === 1'b0, req, 64'(ack_vld), 64'd0);
    check(ack_vec === ev, req, 64'(ack_vec), 64'(ev));
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irq_valid === 1'b0, "R1", 64'(irq_valid), 64'd0);
    check(ack_vld === 1'b0, "R1", 64'(ack_vld), 64'd0);
    check(ack_vec === 8'd0, "R1", 64'(ack_vec), 64'd0);
    check(ack_addr === 32'd0, "R1", 64'(ack_addr), 64'd0);
    check(ack_mask === 4'd0, "R1", 64'(ack_mask), 64'd0);
    // R1 / R2: all priorities 0 after reset, so asserted lines give nothing
    ext_irq = 8'hFF; per_irq = 16'hFFFF; ext_lvl = 4'd15;
    @(negedge clk);
    check(irq_valid === 1'b0, "R2", 64'(irq_valid), 64'd0);
    ext_irq = '0; per_irq = '0; ext_lvl = '0;

    // R6 configuration
    wr(4'd1, BASE0);
    wr(4'd2, W_PINS);
    wr(4'd3, W_PER0);
    wr(4'd4, W_PER1);

    for (int r = 0; r < NV; r++) begin
      logic [45:0] e;
      e = TBL[r];
      if (e[45] != cur_mode) begin
        wr(4'd0, {31'd0, e[45]});
        cur_mode = e[45];
      end
      @(negedge clk);
      ext_irq = e[44:37]; ext_lvl = e[36:33]; per_irq = e[32:17]; cpu_mask = e[16:13];
      @(negedge clk);
      check(irq_valid === e[12], $sformatf("R3/R4/R5/R7 row %0d valid", r), 64'(irq_valid), 64'(e[12]));
      if (e[12]) begin
        check(irq_vec === e[11:4], $sformatf("R3/R4 row %0d vec", r), 64'(irq_vec), 64'(e[11:4]));
        check(irq_level === e[3:0], $sformatf("R3/R6 row %0d level", r), 64'(irq_level), 64'(e[3:0]));
        handshake(e[11:4], e[3:0], BASE0, $sformatf("R8 row %0d", r));
      end
    end

    // back to pin mode, clear inputs
    wr(4'd0, 32'd0);
    ext_irq = '0; per_irq = '0; ext_lvl = '0; cpu_mask = '0;

    // R9 back-pressure: pin6 pending, ready low for several cycles
    @(negedge clk);
    ext_irq = 8'h40;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(irq_valid === 1'b1, "R9 held valid", 64'(irq_valid), 64'd1);
      check(ack_vld === 1'b0, "R9 no ack", 64'(ack_vld), 64'd0);
    end
    handshake(8'd86, 4'd12, BASE0, "R8 after wait");

    // R8 new base applies to next acceptance
    wr(4'd1, 32'h0000_2000);
    ext_irq = '0; per_irq = 16'h0010;
    @(negedge clk);
    check(irq_vec === 8'd100, "R3 periph4", 64'(irq_vec), 64'd100);
    handshake(8'd100, 4'd15, 32'h0000_2000, "R8 base");

    // R2 runtime disable of pin6; R6 pin0 reprogrammed to 14
    wr(4'd2, 32'h5021_077E);
    per_irq = '0; ext_irq = 8'h40;
    @(negedge clk);
    check(irq_valid === 1'b0, "R2 disabled", 64'(irq_valid), 64'd0);
    ext_irq = 8'h41;
    @(negedge clk);
    check(irq_vec === 8'd80, "R6 reprog vec", 64'(irq_vec), 64'd80);
    check(irq_level === 4'd14, "R6 reprog level", 64'(irq_level), 64'd14);

    // R9 request withdrawn before ready: no acceptance
    ext_irq = '0;
    @(negedge clk);
    irq_ready = 1'b1;
    @(negedge clk);
    check(ack_vld === 1'b0, "R9 withdrawn", 64'(ack_vld), 64'd0);
    irq_ready = 1'b0;

    finish_up();
  end
endmodule